// File: doc/BRIEF.md
# Alarm Compare and Interrupt Controller

This block sits beside the time-of-day counter of a real-time clock. It holds two alarm words, one for time and one for calendar, and compares them against the running BCD time and calendar words. Each compared field has its own enable bit inside its alarm word. When every enabled field equals the live value on a second tick, the block raises the alarm flag.

Besides the alarm flag, the block keeps four event flags that the counter reports as one-cycle pulses. All five flags are cleared by writing ones to a dedicated clear strobe. A five-bit interrupt mask is changed only through separate set and clear strobes, and its value is readable as an output. A single registered interrupt line is high whenever a flag and its mask bit are both set.

Bus decode is outside this block. Each register write arrives as a one-cycle strobe that comes with the shared write data.

Top module: `rtc_alarm_irq`

## Requirements
- R1: A synchronous reset clears all flags, the mask, the interrupt output and both alarm words, including every field enable. After reset, a second tick does not raise the alarm flag, whatever the current time is.
- R2: Each event pulse sets its flag in the cycle after the pulse. The flag positions are: update acknowledge at bit 0, alarm at bit 1, second tick at bit 2, time event at bit 3 and calendar event at bit 4.
- R3: A status-clear write clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. The result is visible in the next cycle.
- R4: If a flag is set and cleared in the same cycle, the set wins and the flag ends up 1.
- R5: An enable write sets the mask bits whose data bit is 1, and a disable write clears them. Bits with data 0 keep their value. If both writes hit the same bit in the same cycle, the enable wins. The mask output shows the mask register.
- R6: The time alarm word compares seconds at bits [6:0] (enable bit 7), minutes at bits [14:8] (enable bit 15), and hours together with the AM/PM bit at bits [22:16] (enable bit 23). Each field is compared against the same bits of the current time word.
- R7: The calendar alarm word compares month at bits [20:16] (enable bit 23) and day of month at bits [29:24] (enable bit 31) against the same bits of the current calendar word. Year and century are never compared.
- R8: The alarm flag is set only in a cycle with a second tick in which every enabled field matches. Disabled fields always match. With no field enabled, the alarm never fires. Without a tick, a match does nothing.
- R9: The interrupt output is registered. It goes high one cycle after the AND of flags and mask becomes nonzero, and it goes low one cycle after that AND becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_time | input | 32 | Current BCD time word |
| cur_cal | input | 32 | Current BCD calendar word |
| sec_tick | input | 1 | Second-tick pulse from the counter |
| upd_ack_ev | input | 1 | Update-acknowledge pulse |
| time_ev | input | 1 | Time event pulse |
| cal_ev | input | 1 | Calendar event pulse |
| wr_alm_time | input | 1 | Write strobe for the time alarm word |
| wr_alm_cal | input | 1 | Write strobe for the calendar alarm word |
| wr_irq_en | input | 1 | Write strobe: set mask bits |
| wr_irq_dis | input | 1 | Write strobe: clear mask bits |
| wr_stat_clr | input | 1 | Write strobe: clear flags |
| wr_data | input | 32 | Shared write data |
| status | output | 5 | Flag register |
| mask | output | 5 | Interrupt mask register |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with its defaults: 32-bit words, five flags and five alarm fields. This keeps every real field position in play, including the AM/PM bit inside the hour compare and the missing year compare. Random current-time values are often copied from the alarm word the bench model holds. This makes full matches, single-field mismatches and disabled-field matches all occur during the random run. Writes, clears and event pulses are also timed to collide, which exercises the set-over-clear and enable-over-disable rules.

// File: rtl/rtc_alarm_irq_pkg.sv
`timescale 1ns/1ps
package rtc_alarm_irq_pkg;
  localparam int WORD_W = 32;
  localparam int NFLAG  = 5;
  localparam int NFIELD = 5;

  // flag positions
  localparam int FLG_UPD = 0;
  localparam int FLG_ALM = 1;
  localparam int FLG_SEC = 2;
  localparam int FLG_TIM = 3;
  localparam int FLG_CAL = 4;

  // compared fields: seconds, minutes, hours+ampm, month, day of month
  localparam int FLD_LO  [NFIELD] = '{0, 8, 16, 16, 24};
  localparam int FLD_W   [NFIELD] = '{7, 7, 7, 5, 6};
  localparam int FLD_EN  [NFIELD] = '{7, 15, 23, 23, 31};
  localparam bit FLD_CAL [NFIELD] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
endpackage

// File: rtl/rtc_alm_field_cmp.sv
`timescale 1ns/1ps
module rtc_alm_field_cmp #(
  parameter int WORD_W = 32,
  parameter int LO     = 0,
  parameter int W      = 7,
  parameter int EN_BIT = 7
) (
  input  logic [WORD_W-1:0] alm_word,
  input  logic [WORD_W-1:0] cur_word,
  output logic              fld_en,
  output logic              fld_eq
);
  localparam int HI = LO + W - 1;

  logic unused_rest;
  assign unused_rest = ^{alm_word, cur_word};

  assign fld_en = alm_word[EN_BIT];
  assign fld_eq = (alm_word[HI:LO] == cur_word[HI:LO]);
endmodule

// File: rtl/rtc_alm_match.sv
`timescale 1ns/1ps
module rtc_alm_match
  import rtc_alarm_irq_pkg::*;
#(
  parameter int WW  = WORD_W,
  parameter int NF  = NFIELD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_time,
  input  logic          wr_cal,
  input  logic [WW-1:0] wr_data,
  input  logic [WW-1:0] cur_time,
  input  logic [WW-1:0] cur_cal,
  input  logic          tick,
  output logic          hit
);
  logic [WW-1:0] alm_t, alm_c;
  logic [NF-1:0] en_v, eq_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_t <= '0;
      alm_c <= '0;
    end else begin
      if (wr_time) alm_t <= wr_data;
      if (wr_cal)  alm_c <= wr_data;
    end
  end

  for (genvar f = 0; f < NF; f++) begin : g_fld
    if (FLD_CAL[f]) begin : g_cal
      rtc_alm_field_cmp #(.WORD_W(WW), .LO(FLD_LO[f]), .W(FLD_W[f]), .EN_BIT(FLD_EN[f]))
        u_cmp (.alm_word(alm_c), .cur_word(cur_cal), .fld_en(en_v[f]), .fld_eq(eq_v[f]));
    end else begin : g_tim
      rtc_alm_field_cmp #(.WORD_W(WW), .LO(FLD_LO[f]), .W(FLD_W[f]), .EN_BIT(FLD_EN[f]))
        u_cmp (.alm_word(alm_t), .cur_word(cur_time), .fld_en(en_v[f]), .fld_eq(eq_v[f]));
    end
  end

  assign hit = tick && (|en_v) && (&(eq_v | ~en_v));

  assert_alm_cleared_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (alm_t == '0 && alm_c == '0));
  assert_alm_time_load_R6: assert property (@(posedge clk) disable iff (rst)
    wr_time |=> (alm_t == $past(wr_data)));
  assert_alm_cal_load_R7: assert property (@(posedge clk) disable iff (rst)
    wr_cal |=> (alm_c == $past(wr_data)));
endmodule

// File: rtl/rtc_flag_bank.sv
`timescale 1ns/1ps
module rtc_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags[i]);
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set[i]) |=> !flags[i]);
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!clr[i] && !set[i] && !$past(rst)) |=> $stable(flags[i]));
  end
endmodule

// File: rtl/rtc_irq_mask.sv
`timescale 1ns/1ps
module rtc_irq_mask #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_wr,
  input  logic         dis_wr,
  input  logic [N-1:0] data,
  input  logic [N-1:0] flags,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] set_v, clr_v;
  assign set_v = en_wr  ? data : '0;
  assign clr_v = dis_wr ? data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      mask <= (mask & ~clr_v) | set_v;
      irq  <= |(flags & mask);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_mask_set_R5: assert property (@(posedge clk) disable iff (rst)
      (en_wr && data[i]) |=> mask[i]);
    assert_mask_clr_R5: assert property (@(posedge clk) disable iff (rst)
      (dis_wr && data[i] && !(en_wr && data[i])) |=> !mask[i]);
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
`timescale 1ns/1ps
module rtc_alarm_irq
  import rtc_alarm_irq_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int NF = NFLAG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [WW-1:0] cur_time,
  input  logic [WW-1:0] cur_cal,
  input  logic          sec_tick,
  input  logic          upd_ack_ev,
  input  logic          time_ev,
  input  logic          cal_ev,
  input  logic          wr_alm_time,
  input  logic          wr_alm_cal,
  input  logic          wr_irq_en,
  input  logic          wr_irq_dis,
  input  logic          wr_stat_clr,
  input  logic [WW-1:0] wr_data,
  output logic [NF-1:0] status,
  output logic [NF-1:0] mask,
  output logic          irq
);
  logic          alm_hit;
  logic [NF-1:0] set_v, clr_v;

  rtc_alm_match #(.WW(WW), .NF(NFIELD)) u_match (
    .clk(clk), .rst(rst), .wr_time(wr_alm_time), .wr_cal(wr_alm_cal),
    .wr_data(wr_data), .cur_time(cur_time), .cur_cal(cur_cal),
    .tick(sec_tick), .hit(alm_hit));

  always_comb begin
    set_v          = '0;
    set_v[FLG_UPD] = upd_ack_ev;
    set_v[FLG_ALM] = alm_hit;
    set_v[FLG_SEC] = sec_tick;
    set_v[FLG_TIM] = time_ev;
    set_v[FLG_CAL] = cal_ev;
  end
  assign clr_v = wr_stat_clr ? wr_data[NF-1:0] : '0;

  rtc_flag_bank #(.N(NF)) u_flags (
    .clk(clk), .rst(rst), .set(set_v), .clr(clr_v), .flags(status));

  rtc_irq_mask #(.N(NF)) u_mask (
    .clk(clk), .rst(rst), .en_wr(wr_irq_en), .dis_wr(wr_irq_dis),
    .data(wr_data[NF-1:0]), .flags(status), .mask(mask), .irq(irq));

  assert_alarm_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(status[FLG_ALM]) |-> $past(sec_tick));
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(status) != '0 && $past(mask) != '0));
  assert_event_latch_R2: assert property (@(posedge clk) disable iff (rst)
    (upd_ack_ev && time_ev && cal_ev) |=> (status[FLG_UPD] && status[FLG_TIM] && status[FLG_CAL]));
endmodule

// File: tb/sim_rtc_alarm_irq.sv
`timescale 1ns/1ps
module sim_rtc_alarm_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cur_time = '0, cur_cal = '0, wr_data = '0;
  logic        sec_tick = 0, upd_ack_ev = 0, time_ev = 0, cal_ev = 0;
  logic        wr_alm_time = 0, wr_alm_cal = 0, wr_irq_en = 0, wr_irq_dis = 0, wr_stat_clr = 0;
  logic [4:0]  status, mask;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  logic [4:0]  m_stat = '0, m_mask = '0;
  logic        m_irq = 1'b0;
  logic [31:0] m_at = '0, m_ac = '0;

  always #2.5 clk = ~clk;

  rtc_alarm_irq u0 (
    .clk(clk), .rst(rst), .cur_time(cur_time), .cur_cal(cur_cal),
    .sec_tick(sec_tick), .upd_ack_ev(upd_ack_ev), .time_ev(time_ev), .cal_ev(cal_ev),
    .wr_alm_time(wr_alm_time), .wr_alm_cal(wr_alm_cal), .wr_irq_en(wr_irq_en),
    .wr_irq_dis(wr_irq_dis), .wr_stat_clr(wr_stat_clr), .wr_data(wr_data),
    .status(status), .mask(mask), .irq(irq));

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit mmatch(logic [31:0] at, logic [31:0] ac, logic [31:0] t, logic [31:0] c);
    bit any = 0;
    bit ok  = 1;
    if (at[7])  begin any = 1; if (at[6:0]   != t[6:0])   ok = 0; end
    if (at[15]) begin any = 1; if (at[14:8]  != t[14:8])  ok = 0; end
    if (at[23]) begin any = 1; if (at[22:16] != t[22:16]) ok = 0; end
    if (ac[23]) begin any = 1; if (ac[20:16] != c[20:16]) ok = 0; end
    if (ac[31]) begin any = 1; if (ac[29:24] != c[29:24]) ok = 0; end
    return any && ok;
  endfunction

  // one clock: model update from current inputs, compare at negedge, idle pulses
  task automatic step();
    logic [4:0] setv, clrv, dis, en;
    setv = {cal_ev, time_ev, sec_tick, sec_tick && mmatch(m_at, m_ac, cur_time, cur_cal), upd_ack_ev};
    clrv = wr_stat_clr ? wr_data[4:0] : 5'b0;
    en   = wr_irq_en  ? wr_data[4:0] : 5'b0;
    dis  = wr_irq_dis ? wr_data[4:0] : 5'b0;
    @(posedge clk);
    m_irq  = |(m_stat & m_mask);
    m_stat = (m_stat & ~clrv) | setv;
    m_mask = (m_mask & ~dis) | en;
    if (wr_alm_time) m_at = wr_data;
    if (wr_alm_cal)  m_ac = wr_data;
    @(negedge clk);
    cmp(cur_req, "status", int'(status), int'(m_stat));
    cmp(cur_req, "mask",   int'(mask),   int'(m_mask));
    cmp(cur_req, "irq",    int'(irq),    int'(m_irq));
    sec_tick = 0; upd_ack_ev = 0; time_ev = 0; cal_ev = 0;
    wr_alm_time = 0; wr_alm_cal = 0; wr_irq_en = 0; wr_irq_dis = 0; wr_stat_clr = 0;
  endtask

  task automatic clear_all();
    wr_stat_clr = 1; wr_data = 32'h1F; step();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1", "status after reset", int'(status), 0);
    cmp("R1", "mask after reset", int'(mask), 0);
    cmp("R1", "irq after reset", int'(irq), 0);
    rst = 0;

    // R1: alarm enables cleared, tick with any time gives no alarm
    cur_req = "R1"; cur_time = 32'h0; cur_cal = 32'h0; sec_tick = 1; step();
    cmp("R1", "no alarm after reset", int'(status[1]), 0);

    // R2: each event pulse
    cur_req = "R2";
    upd_ack_ev = 1; step(); cmp("R2", "update flag bit0", int'(status[0]), 1);
    time_ev = 1; step();    cmp("R2", "time flag bit3", int'(status[3]), 1);
    cal_ev = 1; step();     cmp("R2", "cal flag bit4", int'(status[4]), 1);

    // R3: selective clear
    cur_req = "R3";
    wr_stat_clr = 1; wr_data = 32'h05; step();
    cmp("R3", "partial clear", int'(status), 5'b11000);
    clear_all(); cmp("R3", "full clear", int'(status), 0);

    // R4: set beats clear
    cur_req = "R4";
    sec_tick = 1; wr_stat_clr = 1; wr_data = 32'h04; step();
    cmp("R4", "tick flag survives clear", int'(status[2]), 1);
    clear_all();

    // R5: mask set/clear
    cur_req = "R5";
    wr_irq_en = 1; wr_data = 32'h12; step(); cmp("R5", "mask set", int'(mask), 5'b10010);
    wr_irq_dis = 1; wr_data = 32'h02; step(); cmp("R5", "mask clear", int'(mask), 5'b10000);
    wr_irq_en = 1; wr_irq_dis = 1; wr_data = 32'h03; step();
    cmp("R5", "enable wins", int'(mask), 5'b10011);

    // R9: registered irq
    cur_req = "R9";
    upd_ack_ev = 1; step(); cmp("R9", "irq lags flag", int'(irq), 0);
    step(); cmp("R9", "irq high", int'(irq), 1);
    clear_all(); cmp("R9", "irq still high", int'(irq), 1);
    step(); cmp("R9", "irq low", int'(irq), 0);
    time_ev = 1; step(); step(); cmp("R9", "masked flag no irq", int'(irq), 0);
    clear_all();

    // R6: time fields
    cur_req = "R6";
    wr_alm_time = 1; wr_data = 32'h0000_00C5; step();
    cur_time = 32'h0012_3445; sec_tick = 1; step();
    cmp("R6", "seconds alarm", int'(status[1]), 1);
    clear_all();
    wr_alm_time = 1; wr_data = 32'h0000_B0C5; step();
    sec_tick = 1; step();
    cmp("R8", "minute mismatch no alarm", int'(status[1]), 0);
    clear_all();
    wr_alm_time = 1; wr_data = 32'h00D2_0000; step();
    cur_time = 32'h0012_0000; sec_tick = 1; step();
    cmp("R6", "am/pm differs no alarm", int'(status[1]), 0);
    cur_time = 32'h0052_1733; sec_tick = 1; step();
    cmp("R6", "hour+pm alarm, others disabled", int'(status[1]), 1);
    clear_all();

    // R8: no tick, no enables
    cur_req = "R8";
    step(); cmp("R8", "match without tick", int'(status[1]), 0);
    wr_alm_time = 1; wr_data = 32'h0000_0000; step();
    cur_time = 32'h0; sec_tick = 1; step();
    cmp("R8", "no enable never fires", int'(status[1]), 0);
    clear_all();

    // R7: calendar fields
    cur_req = "R7";
    wr_alm_cal = 1; wr_data = 32'hB192_0000; step();
    cur_cal = 32'h3112_2020; sec_tick = 1; step();
    cmp("R7", "month+date alarm", int'(status[1]), 1);
    clear_all();
    cur_cal = 32'h3012_2020; sec_tick = 1; step();
    cmp("R7", "date mismatch", int'(status[1]), 0);
    cur_cal = 32'h3112_9999; sec_tick = 1; step();
    cmp("R7", "year ignored", int'(status[1]), 1);
    clear_all();

    // random mix
    cur_req = "R2,R3,R4,R5,R6,R7,R8,R9";
    for (int i = 0; i < 3000; i++) begin
      sec_tick    = ($urandom % 4) == 0;
      upd_ack_ev  = ($urandom % 8) == 0;
      time_ev     = ($urandom % 8) == 0;
      cal_ev      = ($urandom % 8) == 0;
      wr_alm_time = ($urandom % 16) == 0;
      wr_alm_cal  = ($urandom % 16) == 0;
      wr_irq_en   = ($urandom % 8) == 0;
      wr_irq_dis  = ($urandom % 8) == 0;
      wr_stat_clr = ($urandom % 4) == 0;
      wr_data     = $urandom;
      if ($urandom % 2) cur_time = m_at ^ ((($urandom % 3) == 0) ? 32'h0000_0001 << ($urandom % 23) : 32'h0);
      else              cur_time = $urandom & 32'h007F_7F7F;
      if ($urandom % 2) cur_cal = m_ac | ($urandom & 32'h0000_FFFF);
      else              cur_cal = $urandom;
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule